// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table Controller

This block keeps a table of interrupt message entries and a pending-bit array for a set number of interrupt vectors. Each vector has a 64-bit target address, a 32-bit payload and a control word whose lowest bit masks that vector. The device raises one request pulse per vector. If the vector is open, the block queues a message write made of that entry's address and payload, and hands it out on a valid/ready interface. If the vector is masked, the request is held as a pending bit and is sent later, once, when the vector becomes open again.

Host software reaches the table through a 32-bit read/write port and reads the pending bits through a separate read-only port. Two function-level control bits, enable and mask-all, gate every vector at once. A per-vector "in use" input lets the device leave vectors unused, and requests on those vectors are dropped. When several vectors become ready to send in the same cycle, they leave in ascending vector order, one per accepted handshake.

Top module: `msix_vec_ctrl`

## Requirements
- R1: Vector v occupies byte offsets 16v to 16v+15 of the table port. Offset +0 holds address bits 31:0, +4 holds address bits 63:32, +8 holds the payload and +12 holds the control word. Each word reads back what was last written to it.
- R2: A table read at an offset at or beyond 16 x vector count returns zero, and a table write there changes nothing. A pending-port read beyond the array returns zero. The array spans the vector count rounded up to a multiple of 64 bits.
- R3: A table or pending access is honoured only when all four byte enables are set and the address is word aligned. Any other access returns zero on a read and has no effect on a write.
- R4: Reset, which is synchronous and active high, clears enable and mask-all, zeroes every table word, sets each control word to 1 (bit 0, the per-vector mask, set) and clears all pending bits. Reads complete one cycle after the request.
- R5: A request on an in-use vector that is not masked produces exactly one message. The message carries that entry's address and payload and that vector's index.
- R6: A request on an in-use vector whose control-word bit 0 is set produces no message. It sets pending bit v, which is bit (v mod 32) of pending word (v div 32), at byte offset 4 x (v div 32).
- R7: The whole function counts as masked while enable is clear or mask-all is set. During that time requests only set pending bits.
- R8: A request on a vector whose in-use input is low produces no message and leaves its pending bit clear.
- R9: Clearing a vector's own mask bit while its pending bit is set clears the pending bit and sends that vector's message exactly once.
- R10: A change of the function-level bits that opens the function replays every open vector that has its pending bit set, once each.
- R11: Messages that become ready in the same cycle leave in ascending vector order. An offered message keeps its valid, address, payload and index unchanged until ready is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Load the function control bits |
| ctrl_enable | input | 1 | Enable value loaded on ctrl_wr |
| ctrl_maskall | input | 1 | Mask-all value loaded on ctrl_wr |
| vec_used | input | NUM_VEC | Per-vector in-use flags |
| irq_req | input | NUM_VEC | Per-vector request pulses |
| tbl_wr | input | 1 | Table write strobe |
| tbl_rd | input | 1 | Table read strobe |
| tbl_addr | input | ADDR_W | Table byte address |
| tbl_be | input | 4 | Table byte enables |
| tbl_wdata | input | 32 | Table write data |
| tbl_rdata | output | 32 | Table read data, one cycle after tbl_rd |
| pba_rd | input | 1 | Pending-array read strobe |
| pba_addr | input | PBA_AW | Pending-array byte address |
| pba_be | input | 4 | Pending-array byte enables |
| pba_rdata | output | 32 | Pending-array read data, one cycle after pba_rd |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |
| msg_vec | output | VW | Index of the vector sending the message |

## Verification
The bench builds the block with five vectors, an 8-bit table address and a 4-bit pending address. Five is not a power of two, so table offsets beyond the last entry (0x50 and up) and pending words 2 and 3, which lie past the 64-bit array, can all be reached through the ports. With only five vectors, a single test can raise several same-cycle requests and check their ascending order while the output is stalled, and can also cover masking at vector level and at function level and the unused-vector case.

// File: rtl/msixv_pkg.sv
`timescale 1ns/1ps
package msixv_pkg;

    // word slots inside one 16-byte entry; the order is decoded by address bits 3:2
    typedef enum logic [1:0] {
        SLOT_ADDR_LO = 2'd0,
        SLOT_ADDR_HI = 2'd1,
        SLOT_DATA    = 2'd2,
        SLOT_CTRL    = 2'd3
    } entry_slot_e;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
    } msg_t;

    localparam logic [31:0] CTRL_RESET = 32'h0000_0001;

    // pending array in 32-bit words, rounded to 64-bit multiples
    function automatic int pend_words(int nvec);
        return ((nvec + 63) / 64) * 2;
    endfunction

    function automatic int idx_width(int nvec);
        return (nvec > 1) ? $clog2(nvec) : 1;
    endfunction

endpackage

// File: rtl/msixv_table.sv
`timescale 1ns/1ps
module msixv_table
    import msixv_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int ADDR_W  = 12,
    localparam int VW     = idx_width(NUM_VEC),
    localparam int IDX_W  = ADDR_W - 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NUM_VEC-1:0] vmask,
    input  logic [VW-1:0]     sel_vec,
    output msg_t              sel_msg
);

    logic [31:0] mem [NUM_VEC][4];

    logic [IDX_W-1:0] idx;
    logic [VW-1:0]    vsel;
    logic [1:0]       wsel;
    logic             acc_ok;

    assign idx    = addr[ADDR_W-1:4];
    assign vsel   = idx[VW-1:0];
    assign wsel   = addr[3:2];
    assign acc_ok = (be == 4'hF) && (addr[1:0] == 2'b00) && (idx < IDX_W'(NUM_VEC));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int v = 0; v < NUM_VEC; v++) begin
                for (int w = 0; w < 4; w++) begin
                    mem[v][w] <= (w == int'(SLOT_CTRL)) ? CTRL_RESET : 32'h0;
                end
            end
            rdata <= 32'h0;
        end else begin
            if (wr && acc_ok) begin
                mem[vsel][wsel] <= wdata;
            end
            rdata <= (rd && acc_ok) ? mem[vsel][wsel] : 32'h0;
        end
    end

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_mask
        assign vmask[g] = mem[g][SLOT_CTRL][0];
    end

    assign sel_msg.addr = {mem[sel_vec][SLOT_ADDR_HI], mem[sel_vec][SLOT_ADDR_LO]};
    assign sel_msg.data = mem[sel_vec][SLOT_DATA];

    // R3
    bad_access_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && (be != 4'hF) && !rd) |=> (rdata == 32'h0));

endmodule

// File: rtl/msixv_pend.sv
`timescale 1ns/1ps
module msixv_pend
    import msixv_pkg::*;
#(
    parameter int NUM_VEC  = 8,
    parameter int PBA_AW   = 8,
    localparam int PWORDS  = pend_words(NUM_VEC),
    localparam int PBITS   = PWORDS * 32,
    localparam int PW_W    = PBA_AW - 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] irq,
    input  logic [NUM_VEC-1:0] used,
    input  logic [NUM_VEC-1:0] vmask,
    input  logic               fn_masked,
    input  logic               rd,
    input  logic [PBA_AW-1:0]  addr,
    input  logic [3:0]         be,
    output logic [31:0]        rdata,
    output logic [NUM_VEC-1:0] launch
);

    logic [NUM_VEC-1:0] pend_q, prev_mask_q, cur_mask, opened, req_ok;
    logic [PBITS-1:0]   pend_pad;
    logic [PW_W-1:0]    widx;
    logic               acc_ok;

    assign cur_mask = vmask | {NUM_VEC{fn_masked}};
    assign opened   = prev_mask_q & ~cur_mask;
    assign req_ok   = irq & used;
    assign launch   = (req_ok & ~cur_mask) | (opened & pend_q);

    assign pend_pad = PBITS'(pend_q);
    assign widx     = addr[PBA_AW-1:2];
    assign acc_ok   = (be == 4'hF) && (addr[1:0] == 2'b00) && (widx < PW_W'(PWORDS));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= '0;
            prev_mask_q <= '1;
            rdata       <= 32'h0;
        end else begin
            pend_q      <= (pend_q & ~opened) | (req_ok & cur_mask);
            prev_mask_q <= cur_mask;
            rdata       <= (rd && acc_ok) ? pend_pad[int'(widx)*32 +: 32] : 32'h0;
        end
    end

    // R6
    pend_only_when_masked_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & ~$past(pend_q) & ~$past(cur_mask)) == '0));

    // R8
    unused_never_pending_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & ~$past(pend_q) & ~$past(used)) == '0));

endmodule

// File: rtl/msixv_arb.sv
`timescale 1ns/1ps
module msixv_arb
    import msixv_pkg::*;
#(
    parameter int NUM_VEC = 8,
    localparam int VW     = idx_width(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] launch,
    output logic [VW-1:0]      sel_vec,
    input  msg_t               sel_msg,
    output logic               out_valid,
    input  logic               out_ready,
    output msg_t               out_msg,
    output logic [VW-1:0]      out_vec
);

    logic [NUM_VEC-1:0] deliver_q, grant;
    logic [VW-1:0]      pick;
    logic               hit, slot_free;

    always_comb begin
        pick = '0;
        hit  = 1'b0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (deliver_q[i]) begin
                pick = VW'(i);
                hit  = 1'b1;
            end
        end
    end

    assign slot_free = !out_valid || out_ready;
    assign grant     = (slot_free && hit) ? (NUM_VEC'(1) << pick) : '0;
    assign sel_vec   = pick;

    always_ff @(posedge clk) begin
        if (rst) begin
            deliver_q <= '0;
            out_valid <= 1'b0;
            out_msg   <= '0;
            out_vec   <= '0;
        end else begin
            deliver_q <= (deliver_q & ~grant) | launch;
            if (slot_free) begin
                out_valid <= hit;
                if (hit) begin
                    out_msg <= sel_msg;
                    out_vec <= pick;
                end
            end
        end
    end

    // R11
    one_grant_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));

    // R11
    hold_while_stalled_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_msg) && $stable(out_vec)));

endmodule

// File: rtl/msix_vec_ctrl.sv
`timescale 1ns/1ps
module msix_vec_ctrl
    import msixv_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int ADDR_W  = 12,
    parameter int PBA_AW  = 8,
    localparam int VW     = idx_width(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctrl_wr,
    input  logic               ctrl_enable,
    input  logic               ctrl_maskall,
    input  logic [NUM_VEC-1:0] vec_used,
    input  logic [NUM_VEC-1:0] irq_req,
    input  logic               tbl_wr,
    input  logic               tbl_rd,
    input  logic [ADDR_W-1:0]  tbl_addr,
    input  logic [3:0]         tbl_be,
    input  logic [31:0]        tbl_wdata,
    output logic [31:0]        tbl_rdata,
    input  logic               pba_rd,
    input  logic [PBA_AW-1:0]  pba_addr,
    input  logic [3:0]         pba_be,
    output logic [31:0]        pba_rdata,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data,
    output logic [VW-1:0]      msg_vec
);

    logic               en_q, mall_q, fn_masked;
    logic [NUM_VEC-1:0] vmask, launch;
    logic [VW-1:0]      sel_vec;
    msg_t               sel_msg, out_msg;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            mall_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q   <= ctrl_enable;
            mall_q <= ctrl_maskall;
        end
    end

    assign fn_masked = !en_q || mall_q;

    msixv_table #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) table_i (
        .clk(clk), .rst(rst), .wr(tbl_wr), .rd(tbl_rd), .addr(tbl_addr),
        .be(tbl_be), .wdata(tbl_wdata), .rdata(tbl_rdata), .vmask(vmask),
        .sel_vec(sel_vec), .sel_msg(sel_msg)
    );

    msixv_pend #(.NUM_VEC(NUM_VEC), .PBA_AW(PBA_AW)) pend_i (
        .clk(clk), .rst(rst), .irq(irq_req), .used(vec_used), .vmask(vmask),
        .fn_masked(fn_masked), .rd(pba_rd), .addr(pba_addr), .be(pba_be),
        .rdata(pba_rdata), .launch(launch)
    );

    msixv_arb #(.NUM_VEC(NUM_VEC)) arb_i (
        .clk(clk), .rst(rst), .launch(launch), .sel_vec(sel_vec),
        .sel_msg(sel_msg), .out_valid(msg_valid), .out_ready(msg_ready),
        .out_msg(out_msg), .out_vec(msg_vec)
    );

    assign msg_addr = out_msg.addr;
    assign msg_data = out_msg.data;

    // R4
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!en_q && !mall_q && !msg_valid && (vmask == '1)));

    // R7
    fn_masked_no_launch_chk: assert property (@(posedge clk) disable iff (rst)
        fn_masked |-> (launch == '0));

endmodule

// File: tb/msix_vec_ctrl_tb_top.sv
`timescale 1ns/1ps
module msix_vec_ctrl_tb_top;

    localparam int NV = 5;
    localparam int AW = 8;
    localparam int PW = 4;
    localparam int VWB = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctrl_wr = 0, ctrl_enable = 0, ctrl_maskall = 0;
    logic [NV-1:0] vec_used = '1;
    logic [NV-1:0] irq_req = '0;
    logic tbl_wr = 0, tbl_rd = 0;
    logic [AW-1:0] tbl_addr = '0;
    logic [3:0] tbl_be = 4'hF;
    logic [31:0] tbl_wdata = '0;
    logic [31:0] tbl_rdata;
    logic pba_rd = 0;
    logic [PW-1:0] pba_addr = '0;
    logic [3:0] pba_be = 4'hF;
    logic [31:0] pba_rdata;
    logic msg_valid;
    logic msg_ready = 1'b1;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    logic [VWB-1:0] msg_vec;

    int checks = 0;
    int fails = 0;
    int log_n = 0;
    logic [63:0] log_addr [64];
    logic [31:0] log_data [64];
    int          log_vec  [64];

    always #2.5 clk = ~clk;

    msix_vec_ctrl #(.NUM_VEC(NV), .ADDR_W(AW), .PBA_AW(PW)) dut_i (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_enable(ctrl_enable),
        .ctrl_maskall(ctrl_maskall), .vec_used(vec_used), .irq_req(irq_req),
        .tbl_wr(tbl_wr), .tbl_rd(tbl_rd), .tbl_addr(tbl_addr), .tbl_be(tbl_be),
        .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata), .pba_rd(pba_rd),
        .pba_addr(pba_addr), .pba_be(pba_be), .pba_rdata(pba_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
        .msg_data(msg_data), .msg_vec(msg_vec)
    );

    // handshake monitor: inputs change only at negedge, so this sees the upcoming edge
    always @(negedge clk) begin
        #1;
        if (!rst && msg_valid && msg_ready && log_n < 64) begin
            log_addr[log_n] = msg_addr;
            log_data[log_n] = msg_data;
            log_vec[log_n]  = int'(msg_vec);
            log_n = log_n + 1;
        end
    end

    function automatic logic [63:0] exp_addr(int v);
        return {32'hA000_0000 | 32'(v), 32'h1000_0000 + 32'(v * 16)};
    endfunction

    function automatic logic [31:0] exp_data(int v);
        return 32'hD000_0000 + 32'(v);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic twr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        tbl_wr = 1; tbl_addr = a; tbl_wdata = d; tbl_be = be;
        @(negedge clk);
        tbl_wr = 0; tbl_be = 4'hF;
    endtask

    task automatic trd(input logic [AW-1:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        tbl_rd = 1; tbl_addr = a; tbl_be = be;
        @(negedge clk);
        tbl_rd = 0; tbl_be = 4'hF;
        d = tbl_rdata;
    endtask

    task automatic prd(input logic [PW-1:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        pba_rd = 1; pba_addr = a; pba_be = be;
        @(negedge clk);
        pba_rd = 0; pba_be = 4'hF;
        d = pba_rdata;
    endtask

    task automatic set_ctrl(input logic en, input logic ma);
        @(negedge clk);
        ctrl_wr = 1; ctrl_enable = en; ctrl_maskall = ma;
        @(negedge clk);
        ctrl_wr = 0;
    endtask

    task automatic pulse(input logic [NV-1:0] m);
        @(negedge clk);
        irq_req = m;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic set_vmask(input int v, input logic m);
        twr(AW'(v * 16 + 12), {31'h0, m}, 4'hF);
    endtask

    task automatic expect_msg(input int idx, input int v, input string req);
        chk(log_vec[idx] == v, req, 64'(log_vec[idx]), 64'(v));
        chk(log_addr[idx] == exp_addr(v), req, log_addr[idx], exp_addr(v));
        chk(log_data[idx] == exp_data(v), req, 64'(log_data[idx]), 64'(exp_data(v)));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int v = 0; v < NV; v++) begin
            trd(AW'(v * 16 + 12), 4'hF, d);
            chk(d == 32'h1, "R4 ctrl word after reset", 64'(d), 64'h1);
            trd(AW'(v * 16 + 8), 4'hF, d);
            chk(d == 32'h0, "R4 data word after reset", 64'(d), 64'h0);
        end
        prd(4'h0, 4'hF, d);
        chk(d == 32'h0, "R4 pending after reset", 64'(d), 64'h0);
        chk(log_n == 0, "R4 no message after reset", 64'(log_n), 64'h0);
    endtask

    task automatic t_layout;
        logic [31:0] d;
        logic [63:0] ea;
        for (int v = 0; v < NV; v++) begin
            ea = exp_addr(v);
            twr(AW'(v * 16 + 0), ea[31:0], 4'hF);
            twr(AW'(v * 16 + 4), ea[63:32], 4'hF);
            twr(AW'(v * 16 + 8), exp_data(v), 4'hF);
        end
        for (int v = 0; v < NV; v++) begin
            ea = exp_addr(v);
            trd(AW'(v * 16 + 0), 4'hF, d);
            chk(d == ea[31:0], "R1 addr low readback", 64'(d), 64'(ea[31:0]));
            trd(AW'(v * 16 + 4), 4'hF, d);
            chk(d == ea[63:32], "R1 addr high readback", 64'(d), 64'(ea[63:32]));
            trd(AW'(v * 16 + 8), 4'hF, d);
            chk(d == exp_data(v), "R1 data readback", 64'(d), 64'(exp_data(v)));
        end
    endtask

    task automatic t_range;
        logic [31:0] d;
        twr(8'h50, 32'hFFFF_FFFF, 4'hF);
        trd(8'h50, 4'hF, d);
        chk(d == 32'h0, "R2 read past table", 64'(d), 64'h0);
        trd(8'hFC, 4'hF, d);
        chk(d == 32'h0, "R2 read top of window", 64'(d), 64'h0);
        prd(4'h8, 4'hF, d);
        chk(d == 32'h0, "R2 pending read past array", 64'(d), 64'h0);
        twr(8'h08, 32'h1234_5678, 4'h3);
        trd(8'h08, 4'hF, d);
        chk(d == exp_data(0), "R3 partial write ignored", 64'(d), 64'(exp_data(0)));
        trd(8'h08, 4'h1, d);
        chk(d == 32'h0, "R3 partial read zero", 64'(d), 64'h0);
        trd(8'h09, 4'hF, d);
        chk(d == 32'h0, "R3 misaligned read zero", 64'(d), 64'h0);
        twr(8'h1E, 32'h0, 4'hF);
        trd(8'h1C, 4'hF, d);
        chk(d == 32'h1, "R3 misaligned write ignored", 64'(d), 64'h1);
    endtask

    task automatic t_fire;
        int b;
        logic [31:0] d;
        set_ctrl(1, 0);
        set_vmask(1, 0);
        b = log_n;
        pulse(5'b00010);
        idle(8);
        chk(log_n == b + 1, "R5 one message", 64'(log_n - b), 64'h1);
        if (log_n > b) expect_msg(b, 1, "R5 message content");
        prd(4'h0, 4'hF, d);
        chk(d == 32'h0, "R5 no pending on open vector", 64'(d), 64'h0);
    endtask

    task automatic t_mask;
        int b;
        logic [31:0] d;
        b = log_n;
        pulse(5'b00100);
        idle(8);
        chk(log_n == b, "R6 masked sends nothing", 64'(log_n - b), 64'h0);
        prd(4'h0, 4'hF, d);
        chk(d == 32'h4, "R6 pending bit 2", 64'(d), 64'h4);
        set_vmask(2, 0);
        idle(8);
        chk(log_n == b + 1, "R9 replay once", 64'(log_n - b), 64'h1);
        if (log_n > b) expect_msg(b, 2, "R9 replay content");
        prd(4'h0, 4'hF, d);
        chk(d == 32'h0, "R9 pending cleared", 64'(d), 64'h0);
    endtask

    task automatic t_unused;
        int b;
        logic [31:0] d;
        set_vmask(3, 0);
        @(negedge clk);
        vec_used = 5'b10111;
        b = log_n;
        pulse(5'b01000);
        idle(8);
        chk(log_n == b, "R8 unused open vector silent", 64'(log_n - b), 64'h0);
        set_ctrl(1, 1);
        pulse(5'b01000);
        idle(4);
        prd(4'h0, 4'hF, d);
        chk(d == 32'h0, "R8 unused masked not pending", 64'(d), 64'h0);
        set_ctrl(1, 0);
        idle(6);
        chk(log_n == b, "R8 no replay for unused", 64'(log_n - b), 64'h0);
        @(negedge clk);
        vec_used = '1;
    endtask

    task automatic t_fn;
        int b;
        logic [31:0] d;
        set_vmask(0, 0);
        set_vmask(4, 0);
        set_ctrl(1, 1);
        b = log_n;
        pulse(5'b10001);
        idle(6);
        chk(log_n == b, "R7 mask-all holds requests", 64'(log_n - b), 64'h0);
        prd(4'h0, 4'hF, d);
        chk(d == 32'h11, "R7 pending under mask-all", 64'(d), 64'h11);
        set_ctrl(1, 0);
        idle(8);
        chk(log_n == b + 2, "R10 replay both", 64'(log_n - b), 64'h2);
        if (log_n >= b + 2) begin
            expect_msg(b, 0, "R10 R11 first is vector 0");
            expect_msg(b + 1, 4, "R10 R11 second is vector 4");
        end
        set_ctrl(0, 0);
        b = log_n;
        pulse(5'b00010);
        idle(6);
        chk(log_n == b, "R7 disabled holds requests", 64'(log_n - b), 64'h0);
        prd(4'h0, 4'hF, d);
        chk(d == 32'h2, "R7 pending while disabled", 64'(d), 64'h2);
        set_ctrl(1, 0);
        idle(8);
        chk(log_n == b + 1, "R10 replay after enable", 64'(log_n - b), 64'h1);
        if (log_n > b) expect_msg(b, 1, "R10 replay content");
    endtask

    task automatic t_order;
        int b;
        @(negedge clk);
        msg_ready = 0;
        b = log_n;
        pulse(5'b10011);
        idle(2);
        chk(msg_valid == 1'b1, "R11 offered while stalled", 64'(msg_valid), 64'h1);
        chk(msg_vec == 3'd0, "R11 lowest vector first", 64'(msg_vec), 64'h0);
        idle(4);
        chk(msg_vec == 3'd0 && msg_addr == exp_addr(0), "R11 held while stalled",
            64'(msg_vec), 64'h0);
        @(negedge clk);
        msg_ready = 1;
        idle(8);
        chk(log_n == b + 3, "R11 three messages", 64'(log_n - b), 64'h3);
        if (log_n >= b + 3) begin
            expect_msg(b, 0, "R11 order slot 0");
            expect_msg(b + 1, 1, "R11 order slot 1");
            expect_msg(b + 2, 4, "R11 order slot 2");
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_layout();
        t_range();
        t_fire();
        t_mask();
        t_unused();
        t_fn();
        t_order();
        idle(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule